// File: doc/BRIEF.md
# Operand Address Generator

This block turns the addressing fields of one instruction operand into the address that operand lives at. It takes a 3-bit mode and a 3-bit register field. It also takes the operand size, the current value of the selected address register, the value of the index register, the address of the first extension word and up to two extension words that have already been fetched. From these it works out one of three results. The operand may sit in a register. It may be immediate data in the instruction stream. Otherwise it is a memory operand, and the block gives its 32-bit address.

Alongside the address it reports how many extension words the mode used. For the auto-increment and auto-decrement modes it gives the new address-register value and a write strobe. It raises a flag when a word or long access falls on an odd byte address. It also raises a flag when a brief index word has nonzero reserved bits.

The index-register selection is decoded from the first extension word and driven back out without a register stage, so that the register file can return the index value in the same cycle. All other results pass through an output stage. A parameter makes that stage a register or a plain wire.

Top module: `opnd_addr_unit`

## Requirements
- R1: Modes 000 (data register) and 001 (address register) set `is_reg` and report zero extension words. They give no writeback and an address of zero.
- R2: Mode 010 gives the address register value as the address, with no extension words.
- R3: Mode 011 gives the old address register value as the address. It drives `wb_en` high with `wb_val` equal to the old value plus the step.
- R4: Mode 100 subtracts the step first. Both the address and `wb_val` equal the old value minus the step, and `wb_en` is high.
- R5: The step is 1, 2 or 4 for size 00 (byte), 01 (word) or 10 (long). It is 2 for a byte access when the register field is 7.
- R6: Mode 101 adds the sign-extended first extension word to the address register and reports one extension word.
- R7: In the brief index word, bit 15 selects an address (1) or data (0) index register and bits 14..12 give its number. Both appear at once on `idx_is_addr` and `idx_num`. Bit 11 set uses the full index value; clear uses its sign-extended low 16 bits. Bits 7..0 are a signed displacement. Mode 110 adds the register, the index and the displacement, and reports one word.
- R8: With mode 111, register field 000 gives the sign-extended first word and uses one word. Register field 001 gives the first word as the upper half and the second word as the lower half, and uses two words.
- R9: Mode 111 with register field 010 adds the sign-extended first word to `pc_ext`. Register field 011 adds the index and the 8-bit displacement to `pc_ext`. Each uses one word.
- R10: Mode 111 with register field 100 sets `is_imm` and gives `pc_ext` as the address. It uses two words for long size and one word otherwise.
- R11: `addr_err` rises when a non-register operand has an odd address and either the size is word or long or the operand is immediate. A byte data access at an odd address raises no error.
- R12: In either indexed mode, nonzero bits 10..8 of the brief word raise `bad_ext`. The address is still formed.
- R13: With the output register enabled, results appear one clock after their inputs. A synchronous active-high reset clears every registered output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Addressing mode field |
| reg_sel | input | 3 | Register field, or submode when mode is 111 |
| size | input | 2 | Operand size: 00 byte, 01 word, 10 long |
| an_val | input | AW | Value of the selected address register |
| idx_val | input | AW | Value of the index register named by `idx_num` |
| pc_ext | input | AW | Address of the first extension word |
| ext0 | input | 16 | First extension word |
| ext1 | input | 16 | Second extension word |
| idx_is_addr | output | 1 | Index register is an address register (unregistered) |
| idx_num | output | 3 | Index register number (unregistered) |
| ea_addr | output | AW | Effective address |
| ext_words | output | 2 | Extension words consumed |
| is_reg | output | 1 | Operand is a register |
| is_imm | output | 1 | Operand is immediate data |
| wb_en | output | 1 | Address register update strobe |
| wb_val | output | AW | New address register value |
| addr_err | output | 1 | Odd-address error |
| bad_ext | output | 1 | Brief word reserved bits nonzero |

## Verification
The assertions assume that `size` never carries the reserved code 11. They also assume that `an_val` does not sit where adding or subtracting the step wraps past zero into the same value, which no 32-bit step can do. Every stimulus vector uses one of the three defined sizes. Cases that wrap below zero appear only in pre-decrement, where the checked relation is a difference and so still holds. The undefined submodes 101 to 111 under mode 111 are not driven. The index value is always supplied in the same cycle as the brief word that selects it.

// File: rtl/opnd_addr_pkg.sv
package opnd_addr_pkg;

    localparam logic [2:0] M_DREG    = 3'b000;
    localparam logic [2:0] M_AREG    = 3'b001;
    localparam logic [2:0] M_IND     = 3'b010;
    localparam logic [2:0] M_POSTINC = 3'b011;
    localparam logic [2:0] M_PREDEC  = 3'b100;
    localparam logic [2:0] M_DISP    = 3'b101;
    localparam logic [2:0] M_INDEX   = 3'b110;
    localparam logic [2:0] M_EXTRA   = 3'b111;

    localparam logic [2:0] S_ABS16   = 3'b000;
    localparam logic [2:0] S_ABS32   = 3'b001;
    localparam logic [2:0] S_PCDISP  = 3'b010;
    localparam logic [2:0] S_PCINDEX = 3'b011;
    localparam logic [2:0] S_IMM     = 3'b100;

    localparam logic [1:0] SZ_B = 2'b00;
    localparam logic [1:0] SZ_W = 2'b01;
    localparam logic [1:0] SZ_L = 2'b10;

    localparam logic [2:0] SP_REG = 3'd7;

    typedef struct packed {
        logic is_reg;
        logic is_imm;
        logic wb_en;
        logic addr_err;
        logic bad_ext;
    } oa_flags_t;

    function automatic logic [2:0] step_of(input logic [1:0] sz, input logic is_sp);
        case (sz)
            SZ_B:    return is_sp ? 3'd2 : 3'd1;
            SZ_L:    return 3'd4;
            default: return 3'd2;
        endcase
    endfunction

    function automatic logic [1:0] ext_count(input logic [2:0] md, input logic [2:0] sub,
                                             input logic [1:0] sz);
        case (md)
            M_DISP, M_INDEX: return 2'd1;
            M_EXTRA: begin
                case (sub)
                    S_ABS16, S_PCDISP, S_PCINDEX: return 2'd1;
                    S_ABS32: return 2'd2;
                    S_IMM:   return (sz == SZ_L) ? 2'd2 : 2'd1;
                    default: return 2'd0;
                endcase
            end
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/oa_index_decode.sv
module oa_index_decode
    import opnd_addr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [15:0]   brief,
    input  logic [AW-1:0] idx_val,
    output logic          idx_is_addr,
    output logic [2:0]    idx_num,
    output logic [AW-1:0] idx_off,
    output logic          fmt_bad
);
    logic [AW-1:0] scaled;
    logic [AW-1:0] d8;

    assign idx_is_addr = brief[15];
    assign idx_num     = brief[14:12];
    assign fmt_bad     = |brief[10:8];

    always_comb begin
        scaled  = brief[11] ? idx_val : AW'($signed(idx_val[15:0]));
        d8      = AW'($signed(brief[7:0]));
        idx_off = scaled + d8;
    end
endmodule

// File: rtl/oa_step_gen.sv
module oa_step_gen
    import opnd_addr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    mode,
    input  logic [2:0]    reg_sel,
    input  logic [1:0]    size,
    input  logic [AW-1:0] an_val,
    output logic          wb_en,
    output logic [AW-1:0] wb_val
);
    logic [2:0]    step;
    logic          is_sp;

    assign is_sp = (reg_sel == SP_REG);
    assign step  = step_of(size, is_sp);

    always_comb begin
        wb_en  = 1'b0;
        wb_val = '0;
        if (mode == M_POSTINC) begin
            wb_en  = 1'b1;
            wb_val = an_val + AW'(step);
        end else if (mode == M_PREDEC) begin
            wb_en  = 1'b1;
            wb_val = an_val - AW'(step);
        end
    end

    AST_SP_STEP_EVEN: assert property (@(posedge clk) disable iff (rst)
        (wb_en && is_sp) |-> (wb_val[0] == an_val[0])); // R5

endmodule

// File: rtl/oa_out_stage.sv
module oa_out_stage #(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (REG_OUT) begin : g_flop
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= d;
            end

            AST_OUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> (q == $past(d))); // R13
        end else begin : g_wire
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/opnd_addr_unit.sv
module opnd_addr_unit
    import opnd_addr_pkg::*;
#(
    parameter int AW      = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    mode,
    input  logic [2:0]    reg_sel,
    input  logic [1:0]    size,
    input  logic [AW-1:0] an_val,
    input  logic [AW-1:0] idx_val,
    input  logic [AW-1:0] pc_ext,
    input  logic [15:0]   ext0,
    input  logic [15:0]   ext1,
    output logic          idx_is_addr,
    output logic [2:0]    idx_num,
    output logic [AW-1:0] ea_addr,
    output logic [1:0]    ext_words,
    output logic          is_reg,
    output logic          is_imm,
    output logic          wb_en,
    output logic [AW-1:0] wb_val,
    output logic          addr_err,
    output logic          bad_ext
);
    localparam int FW = $bits(oa_flags_t);
    localparam int PW = 2 * AW + 2 + FW;

    logic [AW-1:0] idx_off;
    logic          fmt_bad;
    logic          wb_en_c;
    logic [AW-1:0] wb_val_c;
    logic [AW-1:0] d16;
    logic [AW-1:0] ea_c;
    logic [1:0]    words_c;
    oa_flags_t     fl;
    logic [PW-1:0] pay_d;
    logic [PW-1:0] pay_q;
    oa_flags_t     fl_q;

    oa_index_decode #(.AW(AW)) u_idx (
        .brief       (ext0),
        .idx_val     (idx_val),
        .idx_is_addr (idx_is_addr),
        .idx_num     (idx_num),
        .idx_off     (idx_off),
        .fmt_bad     (fmt_bad)
    );

    oa_step_gen #(.AW(AW)) u_step (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .reg_sel (reg_sel),
        .size    (size),
        .an_val  (an_val),
        .wb_en   (wb_en_c),
        .wb_val  (wb_val_c)
    );

    assign d16     = AW'($signed(ext0));
    assign words_c = ext_count(mode, reg_sel, size);

    always_comb begin
        ea_c        = '0;
        fl          = '0;
        fl.wb_en    = wb_en_c;
        case (mode)
            M_DREG, M_AREG: fl.is_reg = 1'b1;
            M_IND, M_POSTINC: ea_c = an_val;
            M_PREDEC: ea_c = wb_val_c;
            M_DISP:   ea_c = an_val + d16;
            M_INDEX: begin
                ea_c       = an_val + idx_off;
                fl.bad_ext = fmt_bad;
            end
            default: begin
                case (reg_sel)
                    S_ABS16:  ea_c = d16;
                    S_ABS32:  ea_c = AW'({ext0, ext1});
                    S_PCDISP: ea_c = pc_ext + d16;
                    S_PCINDEX: begin
                        ea_c       = pc_ext + idx_off;
                        fl.bad_ext = fmt_bad;
                    end
                    S_IMM: begin
                        ea_c      = pc_ext;
                        fl.is_imm = 1'b1;
                    end
                    default: ea_c = '0;
                endcase
            end
        endcase
        fl.addr_err = !fl.is_reg && ea_c[0] && (fl.is_imm || size != SZ_B);
    end

    assign pay_d = {ea_c, wb_val_c, words_c, fl};

    oa_out_stage #(.W(PW), .REG_OUT(REG_OUT)) u_out (
        .clk (clk),
        .rst (rst),
        .d   (pay_d),
        .q   (pay_q)
    );

    assign {ea_addr, wb_val, ext_words, fl_q} = pay_q;
    assign is_reg   = fl_q.is_reg;
    assign is_imm   = fl_q.is_imm;
    assign wb_en    = fl_q.wb_en;
    assign addr_err = fl_q.addr_err;
    assign bad_ext  = fl_q.bad_ext;

    AST_REG_NO_WORDS: assert property (@(posedge clk) disable iff (rst)
        fl.is_reg |-> (words_c == 2'd0 && !wb_en_c)); // R1
    AST_POSTINC_OLD_BASE: assert property (@(posedge clk) disable iff (rst)
        (mode == M_POSTINC) |-> (ea_c == an_val && wb_val_c != an_val)); // R3
    AST_PREDEC_STEP_BELOW: assert property (@(posedge clk) disable iff (rst)
        (mode == M_PREDEC) |-> ((an_val - ea_c) == AW'(1) || (an_val - ea_c) == AW'(2)
                                || (an_val - ea_c) == AW'(4))); // R4
    AST_BADEXT_ONE_WORD: assert property (@(posedge clk) disable iff (rst)
        fl.bad_ext |-> (words_c == 2'd1 && !fl.is_reg)); // R12
    AST_IMM_NO_WB: assert property (@(posedge clk) disable iff (rst)
        fl.is_imm |-> (!wb_en_c && words_c != 2'd0)); // R10

endmodule

// File: tb/opnd_addr_unit_bench.sv
module opnd_addr_unit_bench;

    typedef struct packed {
        logic [2:0]  md;
        logic [2:0]  rs;
        logic [1:0]  sz;
        logic [31:0] an;
        logic [31:0] ix;
        logic [31:0] pc;
        logic [15:0] e0;
        logic [15:0] e1;
        logic [31:0] x_ea;
        logic [1:0]  x_w;
        logic [4:0]  x_fl;
        logic [31:0] x_wb;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 24;
    // flags order: is_reg, is_imm, wb_en, addr_err, bad_ext
    localparam vec_t VEC [NV] = '{
        '{3'd0, 3'd3, 2'd2, 32'h1234_5678, 32'h0, 32'h0, 16'h0, 16'h0, 32'h0, 2'd0, 5'b10000, 32'h0, 4'd1},          // R1
        '{3'd1, 3'd5, 2'd1, 32'h1234_5678, 32'h0, 32'h0, 16'h0, 16'h0, 32'h0, 2'd0, 5'b10000, 32'h0, 4'd1},          // R1
        '{3'd2, 3'd2, 2'd2, 32'h0000_1000, 32'h0, 32'h0, 16'h0, 16'h0, 32'h0000_1000, 2'd0, 5'b00000, 32'h0, 4'd2},  // R2
        '{3'd3, 3'd1, 2'd2, 32'h0000_2000, 32'h0, 32'h0, 16'h0, 16'h0, 32'h0000_2000, 2'd0, 5'b00100, 32'h0000_2004, 4'd3}, // R3
        '{3'd3, 3'd7, 2'd0, 32'h0000_3000, 32'h0, 32'h0, 16'h0, 16'h0, 32'h0000_3000, 2'd0, 5'b00100, 32'h0000_3002, 4'd5}, // R5
        '{3'd3, 3'd4, 2'd0, 32'h0000_3001, 32'h0, 32'h0, 16'h0, 16'h0, 32'h0000_3001, 2'd0, 5'b00100, 32'h0000_3002, 4'd5}, // R5
        '{3'd4, 3'd7, 2'd0, 32'h0000_4000, 32'h0, 32'h0, 16'h0, 16'h0, 32'h0000_3FFE, 2'd0, 5'b00100, 32'h0000_3FFE, 4'd5}, // R5
        '{3'd4, 3'd0, 2'd1, 32'h0000_4000, 32'h0, 32'h0, 16'h0, 16'h0, 32'h0000_3FFE, 2'd0, 5'b00100, 32'h0000_3FFE, 4'd4}, // R4
        '{3'd4, 3'd2, 2'd2, 32'h0000_0000, 32'h0, 32'h0, 16'h0, 16'h0, 32'hFFFF_FFFC, 2'd0, 5'b00100, 32'hFFFF_FFFC, 4'd4}, // R4
        '{3'd5, 3'd3, 2'd1, 32'h0000_1000, 32'h0, 32'h0, 16'hFFF0, 16'h0, 32'h0000_0FF0, 2'd1, 5'b00000, 32'h0, 4'd6},    // R6
        '{3'd5, 3'd3, 2'd1, 32'h0000_1000, 32'h0, 32'h0, 16'h7FFF, 16'h0, 32'h0000_8FFF, 2'd1, 5'b00010, 32'h0, 4'd11},   // R11
        '{3'd6, 3'd1, 2'd2, 32'h0000_5000, 32'h0001_FFFE, 32'h0, 16'h3004, 16'h0, 32'h0000_5002, 2'd1, 5'b00000, 32'h0, 4'd7}, // R7
        '{3'd6, 3'd1, 2'd2, 32'h0000_5000, 32'h0001_FFFE, 32'h0, 16'hD8FC, 16'h0, 32'h0002_4FFA, 2'd1, 5'b00000, 32'h0, 4'd7}, // R7
        '{3'd6, 3'd1, 2'd2, 32'h0000_5000, 32'h0001_FFFE, 32'h0, 16'h3104, 16'h0, 32'h0000_5002, 2'd1, 5'b00001, 32'h0, 4'd12}, // R12
        '{3'd7, 3'd0, 2'd1, 32'h0, 32'h0, 32'h0, 16'h8000, 16'h0, 32'hFFFF_8000, 2'd1, 5'b00000, 32'h0, 4'd8},               // R8
        '{3'd7, 3'd1, 2'd2, 32'h0, 32'h0, 32'h0, 16'h0012, 16'h3456, 32'h0012_3456, 2'd2, 5'b00000, 32'h0, 4'd8},            // R8
        '{3'd7, 3'd2, 2'd1, 32'h0, 32'h0, 32'h0000_0102, 16'h0010, 16'h0, 32'h0000_0112, 2'd1, 5'b00000, 32'h0, 4'd9},       // R9
        '{3'd7, 3'd2, 2'd1, 32'h0, 32'h0, 32'h0000_0102, 16'hFFFE, 16'h0, 32'h0000_0100, 2'd1, 5'b00000, 32'h0, 4'd9},       // R9
        '{3'd7, 3'd3, 2'd1, 32'h0, 32'h0000_0010, 32'h0000_0102, 16'h0006, 16'h0, 32'h0000_0118, 2'd1, 5'b00000, 32'h0, 4'd9}, // R9
        '{3'd7, 3'd4, 2'd2, 32'h0, 32'h0, 32'h0000_0200, 16'h0, 16'h0, 32'h0000_0200, 2'd2, 5'b01000, 32'h0, 4'd10},         // R10
        '{3'd7, 3'd4, 2'd0, 32'h0, 32'h0, 32'h0000_0200, 16'h0, 16'h0, 32'h0000_0200, 2'd1, 5'b01000, 32'h0, 4'd10},         // R10
        '{3'd2, 3'd0, 2'd2, 32'h0000_1001, 32'h0, 32'h0, 16'h0, 16'h0, 32'h0000_1001, 2'd0, 5'b00010, 32'h0, 4'd11},         // R11
        '{3'd2, 3'd0, 2'd0, 32'h0000_1001, 32'h0, 32'h0, 16'h0, 16'h0, 32'h0000_1001, 2'd0, 5'b00000, 32'h0, 4'd11},         // R11
        '{3'd7, 3'd4, 2'd1, 32'h0, 32'h0, 32'h0000_0201, 16'h0, 16'h0, 32'h0000_0201, 2'd1, 5'b01010, 32'h0, 4'd11}          // R11
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode = '0;
    logic [2:0]  reg_sel = '0;
    logic [1:0]  size = '0;
    logic [31:0] an_val = '0;
    logic [31:0] idx_val = '0;
    logic [31:0] pc_ext = '0;
    logic [15:0] ext0 = '0;
    logic [15:0] ext1 = '0;
    logic        idx_is_addr;
    logic [2:0]  idx_num;
    logic [31:0] ea_addr;
    logic [1:0]  ext_words;
    logic        is_reg, is_imm, wb_en, addr_err, bad_ext;
    logic [31:0] wb_val;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    opnd_addr_unit u_opnd_addr_unit (
        .clk(clk), .rst(rst), .mode(mode), .reg_sel(reg_sel), .size(size),
        .an_val(an_val), .idx_val(idx_val), .pc_ext(pc_ext), .ext0(ext0), .ext1(ext1),
        .idx_is_addr(idx_is_addr), .idx_num(idx_num), .ea_addr(ea_addr),
        .ext_words(ext_words), .is_reg(is_reg), .is_imm(is_imm), .wb_en(wb_en),
        .wb_val(wb_val), .addr_err(addr_err), .bad_ext(bad_ext)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        mode = v.md; reg_sel = v.rs; size = v.sz; an_val = v.an; idx_val = v.ix;
        pc_ext = v.pc; ext0 = v.e0; ext1 = v.e1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R13: reset clears outputs even with live inputs
        apply(VEC[3]);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R13 reset ea", ea_addr, 32'h0);
        check("R13 reset flags", {27'h0, is_reg, is_imm, wb_en, addr_err, bad_ext}, 32'h0);
        check("R13 reset wb", wb_val, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VEC[i]);
            @(negedge clk);
            check($sformatf("R%0d v%0d ea", VEC[i].rq, i), ea_addr, VEC[i].x_ea);
            check($sformatf("R%0d v%0d words", VEC[i].rq, i), {30'h0, ext_words}, {30'h0, VEC[i].x_w});
            check($sformatf("R%0d v%0d flags", VEC[i].rq, i),
                  {27'h0, is_reg, is_imm, wb_en, addr_err, bad_ext}, {27'h0, VEC[i].x_fl});
            check($sformatf("R%0d v%0d wb", VEC[i].rq, i), wb_val, VEC[i].x_wb);
        end

        // R7: index selection visible combinationally
        @(negedge clk);
        apply(VEC[12]);
        #1;
        check("R7 idx_is_addr", {31'h0, idx_is_addr}, 32'h1);
        check("R7 idx_num", {29'h0, idx_num}, 32'h5);
        ext0 = 16'h3004;
        #1;
        check("R7 idx data kind", {31'h0, idx_is_addr}, 32'h0);
        check("R7 idx_num 3", {29'h0, idx_num}, 32'h3);

        // R13: one-cycle latency, old result held until the edge
        @(negedge clk);
        apply(VEC[0]);
        @(negedge clk);
        apply(VEC[3]);
        #1;
        check("R13 hold before edge", {31'h0, is_reg}, 32'h1);
        @(negedge clk);
        check("R13 after edge ea", ea_addr, 32'h0000_2000);
        check("R13 after edge wb", wb_val, 32'h0000_2004);

        // R13: reset mid-run clears outputs
        rst = 1'b1;
        @(negedge clk);
        check("R13 mid reset ea", ea_addr, 32'h0);
        check("R13 mid reset wb_en", {31'h0, wb_en}, 32'h0);
        rst = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule